// File: doc/BRIEF.md
# Associative Page Translation Table

This block maps processor virtual addresses onto physical RAM addresses. The table has one slot per physical page. Each slot holds the virtual page number at which that physical page shows up in the processor's map, plus a valid flag. A lookup compares the virtual page number of the incoming address against every slot at once. The physical address is then formed from the index of the matching slot, which is the physical page number, joined to the untouched in-page offset. When no valid slot matches, the block reports a fault.

On a task switch, software rewrites slots through a single write port. Two tasks can therefore use the same virtual addresses while reaching different physical pages. A clear-all control empties the whole table in one cycle. If duplicate mappings exist, the lowest-numbered slot wins, so the result is always deterministic. Each lookup is answered exactly one clock cycle after it is presented.

Top module: `ptt_translate`

## Requirements
- R1: After reset every slot is invalid, so any lookup faults, and `rsp_valid`, `rsp_hit` and `rsp_fault` are all 0.
- R2: When `wr_en` is high at a rising clock edge, slot `wr_idx` takes `wr_vpn` as its virtual page number and `wr_valid` as its valid flag. Later lookups see the new contents.
- R3: A lookup presented with `lk_valid` at edge N is answered after edge N. If a match is found, the answer is `rsp_valid=1`, `rsp_hit=1`, `rsp_fault=0` and `rsp_pa = {slot index (7 bits), lk_va[11:0]}`. The virtual page number is `lk_va[19:12]`.
- R4: A lookup with no valid matching slot is answered with `rsp_valid=1`, `rsp_fault=1` and `rsp_hit=0`.
- R5: When several valid slots hold the searched virtual page number, the slot with the lowest index supplies the physical page.
- R6: A slot whose valid flag is 0 never matches, whatever virtual page number it holds.
- R7: `clr_all` invalidates every slot at the next edge. When `clr_all` and `wr_en` arrive in the same cycle, the clear wins and the write is dropped.
- R8: A lookup in the same cycle as a write is translated with the table contents from before that write.
- R9: A cycle without `lk_valid` produces `rsp_valid=0`, `rsp_hit=0` and `rsp_fault=0` on the following cycle.
- R10: Rewriting a slot with a new virtual page number removes the old mapping: the old page then faults and the new page hits that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write one slot this cycle |
| wr_idx | input | 7 | Slot (physical page) being written |
| wr_vpn | input | 8 | Virtual page number stored in the slot |
| wr_valid | input | 1 | Valid flag stored in the slot |
| clr_all | input | 1 | Invalidate every slot |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_va | input | 20 | Virtual address to translate |
| rsp_valid | output | 1 | Lookup answer present |
| rsp_hit | output | 1 | Translation found |
| rsp_fault | output | 1 | No valid slot matched |
| rsp_pa | output | 19 | Physical address; meaningful only with `rsp_hit` |

## Verification
Each lookup result reaches the outputs one register stage after the request: a request held across edge N appears after edge N. The bench drives inputs on the falling edge, lets one rising edge pass, and samples on the following falling edge. A table write or clear takes effect at the edge where it is presented. The bench therefore issues the lookup that depends on it in a later cycle, except in the same-cycle case, where the answer must still reflect the old contents.

// File: rtl/ptt_pkg.sv
package ptt_pkg;
    localparam int unsigned PTT_PAGES = 128;
    localparam int unsigned PTT_VPN_W = 8;
    localparam int unsigned PTT_OFS_W = 12;

    typedef enum logic [1:0] {
        RSP_IDLE  = 2'd0,
        RSP_HIT   = 2'd1,
        RSP_FAULT = 2'd2
    } rsp_kind_t;
endpackage

// File: rtl/ptt_store.sv
module ptt_store #(
    parameter int unsigned PAGES = ptt_pkg::PTT_PAGES,
    parameter int unsigned VPN_W = ptt_pkg::PTT_VPN_W,
    localparam int unsigned IDX_W = $clog2(PAGES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic             wr_valid,
    input  logic             clr_all,
    output logic [PAGES-1:0] vld_o,
    output logic [VPN_W-1:0] vpn_o [PAGES]
);
    logic [PAGES-1:0] vld_d, vld_q;
    logic [VPN_W-1:0] vpn_d [PAGES];
    logic [VPN_W-1:0] vpn_q [PAGES];

    always_comb begin
        vld_d = vld_q;
        vpn_d = vpn_q;
        if (clr_all) begin
            vld_d = '0;
        end else if (wr_en) begin
            vld_d[wr_idx] = wr_valid;
            vpn_d[wr_idx] = wr_vpn;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < int'(PAGES); i++) vpn_q[i] <= '0;
        end else begin
            vld_q <= vld_d;
            vpn_q <= vpn_d;
        end
    end

    assign vld_o = vld_q;
    assign vpn_o = vpn_q;

    // R7: a clear empties the table at the next edge, regardless of a write
    a_r7_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        clr_all |=> (vld_q == '0));

    // R2: a write lands in the addressed slot
    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr_all) |=> (vld_q[$past(wr_idx)] == $past(wr_valid))
                                && (vpn_q[$past(wr_idx)] == $past(wr_vpn)));
endmodule

// File: rtl/ptt_match.sv
module ptt_match #(
    parameter int unsigned PAGES = ptt_pkg::PTT_PAGES,
    parameter int unsigned VPN_W = ptt_pkg::PTT_VPN_W
) (
    input  logic [PAGES-1:0] vld_i,
    input  logic [VPN_W-1:0] vpn_i [PAGES],
    input  logic [VPN_W-1:0] key_i,
    output logic [PAGES-1:0] match_o
);
    for (genvar g = 0; g < int'(PAGES); g++) begin : g_cmp
        assign match_o[g] = vld_i[g] && (vpn_i[g] == key_i);
    end
endmodule

// File: rtl/ptt_lowest.sv
module ptt_lowest #(
    parameter int unsigned N = ptt_pkg::PTT_PAGES,
    localparam int unsigned IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = int'(N) - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
        any_o = |req_i;
    end
endmodule

// File: rtl/ptt_translate.sv
module ptt_translate #(
    parameter int unsigned PAGES = ptt_pkg::PTT_PAGES,
    parameter int unsigned VPN_W = ptt_pkg::PTT_VPN_W,
    parameter int unsigned OFS_W = ptt_pkg::PTT_OFS_W,
    localparam int unsigned IDX_W = $clog2(PAGES),
    localparam int unsigned VA_W  = VPN_W + OFS_W,
    localparam int unsigned PA_W  = IDX_W + OFS_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic             wr_valid,
    input  logic             clr_all,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_va,
    output logic             rsp_valid,
    output logic             rsp_hit,
    output logic             rsp_fault,
    output logic [PA_W-1:0]  rsp_pa
);
    import ptt_pkg::*;

    typedef struct packed {
        rsp_kind_t       kind;
        logic [PA_W-1:0] pa;
    } rsp_state_t;

    logic [PAGES-1:0] tbl_vld;
    logic [VPN_W-1:0] tbl_vpn [PAGES];
    logic [PAGES-1:0] match_vec;
    logic             enc_any;
    logic [IDX_W-1:0] enc_idx;
    rsp_state_t       rsp_d, rsp_q;

    ptt_store #(.PAGES(PAGES), .VPN_W(VPN_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_vpn   (wr_vpn),
        .wr_valid (wr_valid),
        .clr_all  (clr_all),
        .vld_o    (tbl_vld),
        .vpn_o    (tbl_vpn)
    );

    ptt_match #(.PAGES(PAGES), .VPN_W(VPN_W)) u_match (
        .vld_i   (tbl_vld),
        .vpn_i   (tbl_vpn),
        .key_i   (lk_va[VA_W-1:OFS_W]),
        .match_o (match_vec)
    );

    ptt_lowest #(.N(PAGES)) u_lowest (
        .req_i (match_vec),
        .any_o (enc_any),
        .idx_o (enc_idx)
    );

    always_comb begin
        rsp_d = '{kind: RSP_IDLE, pa: '0};
        if (lk_valid) begin
            if (enc_any) begin
                rsp_d.kind = RSP_HIT;
                rsp_d.pa   = {enc_idx, lk_va[OFS_W-1:0]};
            end else begin
                rsp_d.kind = RSP_FAULT;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '{kind: RSP_IDLE, pa: '0};
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = (rsp_q.kind != RSP_IDLE);
    assign rsp_hit   = (rsp_q.kind == RSP_HIT);
    assign rsp_fault = (rsp_q.kind == RSP_FAULT);
    assign rsp_pa    = rsp_q.pa;

    // R3/R4: every answer is exactly one of hit or fault
    a_r4_hit_xor_fault: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit != rsp_fault));

    // R9: answers follow requests by one cycle, and only requests
    a_r9_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    a_r9_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!rsp_valid && !rsp_hit && !rsp_fault));

    // R3: the offset passes through unchanged
    a_r3_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && enc_any) |=> (rsp_pa[OFS_W-1:0] == $past(lk_va[OFS_W-1:0])));

    // R5: the selected slot matches and no lower slot does
    a_r5_sel_matches: assert property (@(posedge clk) disable iff (!rst_n)
        enc_any |-> match_vec[enc_idx]);
    a_r5_none_lower: assert property (@(posedge clk) disable iff (!rst_n)
        enc_any |-> ((match_vec & ((PAGES'(1) << enc_idx) - PAGES'(1))) == '0));

    // R6: invalid slots never appear in the match vector
    a_r6_invalid_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (match_vec & ~tbl_vld) == '0);
endmodule

// File: tb/ptt_translate_bench.sv
module ptt_translate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [6:0]  wr_idx = '0;
    logic [7:0]  wr_vpn = '0;
    logic        wr_valid = 1'b0;
    logic        clr_all = 1'b0;
    logic        lk_valid = 1'b0;
    logic [19:0] lk_va = '0;
    logic        rsp_valid, rsp_hit, rsp_fault;
    logic [18:0] rsp_pa;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    ptt_translate u_ptt_translate (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_vpn(wr_vpn), .wr_valid(wr_valid), .clr_all(clr_all),
        .lk_valid(lk_valid), .lk_va(lk_va), .rsp_valid(rsp_valid),
        .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa)
    );

    task automatic check(input string req, input logic [22:0] act, input logic [22:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // response sampled as {valid, hit, fault, pa}
    function automatic logic [22:0] rsp_now();
        return {1'b0, rsp_valid, rsp_hit, rsp_fault, rsp_pa};
    endfunction

    function automatic logic [22:0] exp_hit(input logic [6:0] idx, input logic [11:0] ofs);
        return {1'b0, 3'b110, idx, ofs};
    endfunction

    function automatic logic [2:0] flags();
        return {rsp_valid, rsp_hit, rsp_fault};
    endfunction

    task automatic write_slot(input logic [6:0] idx, input logic [7:0] vpn, input logic v);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_vpn = vpn; wr_valid = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic lookup_hit(input string req, input logic [19:0] va, input logic [6:0] idx);
        @(negedge clk);
        lk_valid = 1'b1; lk_va = va;
        @(negedge clk);
        lk_valid = 1'b0;
        check(req, rsp_now(), exp_hit(idx, va[11:0]));
    endtask

    task automatic lookup_miss(input string req, input logic [19:0] va);
        @(negedge clk);
        lk_valid = 1'b1; lk_va = va;
        @(negedge clk);
        lk_valid = 1'b0;
        check(req, {20'd0, flags()}, {20'd0, 3'b101});
    endtask

    task automatic t_reset();
        check("R1 idle flags after reset", {20'd0, flags()}, 23'd0);
        lookup_miss("R1 empty table faults", 20'h00_123);
    endtask

    task automatic t_basic();
        write_slot(7'd5, 8'h12, 1'b1);
        lookup_hit("R2 R3 written slot hits", 20'h12_ABC, 7'd5);
        lookup_miss("R4 unmapped page faults", 20'h13_ABC);
    endtask

    task automatic t_bounds();
        write_slot(7'd0, 8'hFF, 1'b1);
        write_slot(7'd127, 8'h00, 1'b1);
        lookup_hit("R3 slot 0 top page", 20'hFF_FFF, 7'd0);
        lookup_hit("R3 slot 127 page 0", 20'h00_000, 7'd127);
    endtask

    task automatic t_priority();
        write_slot(7'd40, 8'h55, 1'b1);
        write_slot(7'd9, 8'h55, 1'b1);
        lookup_hit("R5 lowest duplicate wins", 20'h55_0F0, 7'd9);
        write_slot(7'd9, 8'h55, 1'b0);
        lookup_hit("R6 invalidated slot skipped", 20'h55_0F1, 7'd40);
        write_slot(7'd60, 8'h66, 1'b0);
        lookup_miss("R6 invalid write never matches", 20'h66_000);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 7'd70; wr_vpn = 8'h77; wr_valid = 1'b1;
        lk_valid = 1'b1; lk_va = 20'h77_321;
        @(negedge clk);
        wr_en = 1'b0; lk_valid = 1'b0;
        check("R8 lookup sees old table", {20'd0, flags()}, {20'd0, 3'b101});
        lookup_hit("R8 next lookup sees write", 20'h77_321, 7'd70);
    endtask

    task automatic t_remap();
        write_slot(7'd5, 8'h21, 1'b1);
        lookup_miss("R10 old page gone", 20'h12_ABC);
        lookup_hit("R10 new page mapped", 20'h21_456, 7'd5);
    endtask

    task automatic t_idle();
        @(negedge clk);
        lk_valid = 1'b0; lk_va = 20'h21_456;
        @(negedge clk);
        check("R9 no request no answer", {20'd0, flags()}, 23'd0);
    endtask

    task automatic t_clear();
        @(negedge clk);
        clr_all = 1'b1;
        wr_en = 1'b1; wr_idx = 7'd80; wr_vpn = 8'h88; wr_valid = 1'b1;
        @(negedge clk);
        clr_all = 1'b0; wr_en = 1'b0;
        lookup_miss("R7 clear drops mapping", 20'h21_000);
        lookup_miss("R7 clear beats write", 20'h88_000);
        lookup_miss("R7 slot 0 cleared", 20'hFF_000);
        write_slot(7'd3, 8'h31, 1'b1);
        lookup_hit("R2 write after clear", 20'h31_777, 7'd3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_bounds();
        t_priority();
        t_same_cycle();
        t_remap();
        t_idle();
        t_clear();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule